// File: doc/BRIEF.md
# Two-Level Lookahead Carry Generator

This block produces every carry-in bit of a 32-bit addition, plus the carry-out, without forming the sum itself. The consumer takes sum bit i as `a[i] ^ b[i] ^ carry[i]`. Because the result is a carry vector and not a sum, a datapath that feeds the sum into more XOR stages can merge those XORs with the sum XOR or move them around it, which shortens its critical path.

The carries come from two lookahead levels. The first level has eight 4-bit groups. Each group forms bit generate (`a & b`) and bit propagate (`a ^ b`) and reduces them to a group generate and a group propagate. The second level combines the eight group generate/propagate pairs with the external carry-in to produce each group's carry-in. Each group then expands its own carry-in into the carries of its four bits. The same lookahead unit is used at both levels.

The top module is a thin registered wrapper for checking. It samples the operands on a clock edge and presents the carry vector, the carry-out and the sum formed from them. Addition wraps modulo 2^32.

Top module: `carry_gen_top`

## Requirements
- R1: One clock edge after the operands and carry-in are sampled, `sum_q` equals (`op_a` + `op_b` + `carry_in`) modulo 2^32.
- R2: `carry_out_q` equals bit 32 of the 33-bit value `op_a` + `op_b` + `carry_in`, which is the carry out of bit 31.
- R3: `carries_q[0]` equals the sampled `carry_in`.
- R4: For i from 0 to 30, `carries_q[i+1]` is the majority of `op_a[i]`, `op_b[i]` and `carries_q[i]`. Over the whole vector, `carries_q` equals (`op_a` + `op_b` + `carry_in`) XOR `op_a` XOR `op_b`, taking bits 31..0.
- R5: Each bit i of `sum_q` equals `op_a[i] ^ op_b[i] ^ carries_q[i]` for the sampled operands.
- R6: When `rst` is high at a rising clock edge, `sum_q`, `carries_q` and `carry_out_q` become all zeros and stay zero until the first edge that samples with `rst` low.
- R7: All-ones plus one wraps. 0xFFFFFFFF + 0 with carry-in 1, and 0xFFFFFFFF + 1 with carry-in 0, both give sum 0 and carry-out 1. In the first case every carry bit is 1.
- R8: A carry that runs through whole 4-bit groups reaches the far group and the carry-out. Examples are 0xAAAAAAAA + 0x55555555 + 1 and 0x0000000F + 1, where the second crosses the boundary between bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| carries_q | output | 32 | Registered carry into each bit position |
| carry_out_q | output | 1 | Registered carry out of bit 31 |
| sum_q | output | 32 | Registered sum formed by XOR of operands and carries |

## Verification
The assertions in the wrapper check every cycle against the previously sampled operands:
- the sum and carry-out match a plain addition;
- bit 0 of the carry vector is the carry-in;
- each higher carry bit is the majority of the bit below;
- the sum is the three-way XOR;
- the outputs are zero until the first sample after reset.

Only the bench scenarios show that the generated lookahead products are correct for specific patterns. These patterns are long propagate chains through every group, carries that cross a single group boundary, the all-ones wrap cases, and a mid-run reset that clears live non-zero outputs.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // Default partitioning of the adder into lookahead groups
  parameter int unsigned CG_GROUP_W = 4;
  parameter int unsigned CG_GROUPS  = 8;

  // Majority of three bits: the carry rule for one bit position
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/cg_lookahead.sv
// Generic lookahead unit: from per-position generate/propagate and a carry-in,
// forms the carry into every position as flat sum-of-products (no ripple),
// plus the block generate/propagate that do not depend on the carry-in.
module cg_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W-1:0] cvec,
  output logic         blk_gen,
  output logic         blk_prop
);

  always_comb begin
    for (int j = 0; j < W; j++) begin
      logic acc;
      logic term;
      term = cin;
      for (int k = 0; k < j; k++) term = term & prop[k];
      acc = term;
      for (int k = 0; k < j; k++) begin
        logic t;
        t = gen[k];
        for (int m = k + 1; m < j; m++) t = t & prop[m];
        acc = acc | t;
      end
      cvec[j] = acc;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < W; k++) begin
      logic t;
      t = gen[k];
      for (int m = k + 1; m < W; m++) t = t & prop[m];
      acc = acc | t;
    end
    blk_gen  = acc;
    blk_prop = &prop;
  end

endmodule

// File: rtl/cg_group.sv
// First-level group: bit generate/propagate, group G/P, and bit carries
// expanded from the group carry-in supplied by the second level.
module cg_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          grp_cin,
  output logic [GW-1:0] bit_carry,
  output logic          grp_gen,
  output logic          grp_prop
);

  logic [GW-1:0] bit_gen;
  logic [GW-1:0] bit_prop;

  assign bit_gen  = a & b;
  assign bit_prop = a ^ b;

  cg_lookahead #(.W(GW)) la_i (
    .gen      (bit_gen),
    .prop     (bit_prop),
    .cin      (grp_cin),
    .cvec     (bit_carry),
    .blk_gen  (grp_gen),
    .blk_prop (grp_prop)
  );

endmodule

// File: rtl/carry_gen32.sv
// Combinational two-level carry generator.
module carry_gen32
  import cg_pkg::*;
#(
  parameter int unsigned GROUP_W = CG_GROUP_W,
  parameter int unsigned GROUPS  = CG_GROUPS
) (
  input  logic [GROUP_W*GROUPS-1:0] a,
  input  logic [GROUP_W*GROUPS-1:0] b,
  input  logic                      cin,
  output logic [GROUP_W*GROUPS-1:0] carries,
  output logic                      cout
);

  logic [GROUPS-1:0] grp_gen;
  logic [GROUPS-1:0] grp_prop;
  logic [GROUPS-1:0] grp_cin;
  logic              top_gen;
  logic              top_prop;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    cg_group #(.GW(GROUP_W)) grp_i (
      .a         (a[gi*GROUP_W +: GROUP_W]),
      .b         (b[gi*GROUP_W +: GROUP_W]),
      .grp_cin   (grp_cin[gi]),
      .bit_carry (carries[gi*GROUP_W +: GROUP_W]),
      .grp_gen   (grp_gen[gi]),
      .grp_prop  (grp_prop[gi])
    );
  end

  // Second level: group carry-ins from group G/P and the external carry-in
  cg_lookahead #(.W(GROUPS)) lvl2_i (
    .gen      (grp_gen),
    .prop     (grp_prop),
    .cin      (cin),
    .cvec     (grp_cin),
    .blk_gen  (top_gen),
    .blk_prop (top_prop)
  );

  assign cout = top_gen | (top_prop & cin);

endmodule

// File: rtl/carry_gen_top.sv
// Registered check wrapper: samples operands, presents carries and the
// sum formed by XOR of operands and carries.
module carry_gen_top
  import cg_pkg::*;
#(
  parameter int unsigned GROUP_W = CG_GROUP_W,
  parameter int unsigned GROUPS  = CG_GROUPS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GROUP_W*GROUPS-1:0] op_a,
  input  logic [GROUP_W*GROUPS-1:0] op_b,
  input  logic                      carry_in,
  output logic [GROUP_W*GROUPS-1:0] carries_q,
  output logic                      carry_out_q,
  output logic [GROUP_W*GROUPS-1:0] sum_q
);

  localparam int unsigned W = GROUP_W * GROUPS;

  logic [W-1:0] carries_c;
  logic         cout_c;
  logic         primed_q;

  carry_gen32 #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) core_i (
    .a       (op_a),
    .b       (op_b),
    .cin     (carry_in),
    .carries (carries_c),
    .cout    (cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carries_q   <= '0;
      carry_out_q <= 1'b0;
      sum_q       <= '0;
      primed_q    <= 1'b0;
    end else begin
      carries_q   <= carries_c;
      carry_out_q <= cout_c;
      sum_q       <= op_a ^ op_b ^ carries_c;
      primed_q    <= 1'b1;
    end
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (sum_q == W'($past(op_a) + $past(op_b) + W'($past(carry_in))))); // R1

  AST_COUT_MATCH: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (carry_out_q == (({1'b0, $past(op_a)} + {1'b0, $past(op_b)}
                                   + {{W{1'b0}}, $past(carry_in)}) >> W))); // R2

  AST_C0_IS_CIN: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (carries_q[0] == $past(carry_in))); // R3

  AST_CARRY_CHAIN: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (carries_q[W-1:1] ==
      (($past(op_a[W-2:0]) & $past(op_b[W-2:0])) |
       (($past(op_a[W-2:0]) ^ $past(op_b[W-2:0])) & carries_q[W-2:0])))); // R4

  AST_COUT_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (carry_out_q == maj3($past(op_a[W-1]), $past(op_b[W-1]), carries_q[W-1]))); // R2

  AST_SUM_XOR: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (sum_q == ($past(op_a) ^ $past(op_b) ^ carries_q))); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !primed_q |-> (sum_q == '0 && carries_q == '0 && !carry_out_q)); // R6

endmodule

// File: tb/carry_gen_top_tb_top.sv
module carry_gen_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] exp_sum;
    logic [W-1:0] exp_carries;
    logic         exp_cout;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] carries_q;
  logic         carry_out_q;
  logic [W-1:0] sum_q;

  int n_chk  = 0;
  int n_fail = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_gen_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .carries_q   (carries_q),
    .carry_out_q (carry_out_q),
    .sum_q       (sum_q)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: drive on falling edge, push behavioural expectation
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input string tag);
    item_t it;
    logic [W:0] full;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    it.a = a; it.b = b; it.cin = c;
    it.exp_sum = full[W-1:0];
    it.exp_cout = full[W];
    it.exp_carries = full[W-1:0] ^ a ^ b;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: one item per edge, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({"R1 sum ", it.tag}, sum_q, it.exp_sum);
        check({"R2 cout ", it.tag}, {31'b0, carry_out_q}, {31'b0, it.exp_cout});
        check({"R3 c0 ", it.tag}, {31'b0, carries_q[0]}, {31'b0, it.cin});
        check({"R4 carries ", it.tag}, carries_q, it.exp_carries);
        check({"R5 sum xor ", it.tag}, sum_q, it.a ^ it.b ^ carries_q);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R6: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset sum", sum_q, '0);
    check("R6 reset carries", carries_q, '0);
    check("R6 reset cout", {31'b0, carry_out_q}, '0);
    @(negedge clk); rst = 1'b0;

    drive(32'h0, 32'h0, 1'b0, "zero");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R7 ones+cin");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R7 ones+one");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 ones+ones+1");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R8 full propagate");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R8 propagate no cin");
    drive(32'h0000_000F, 32'h1, 1'b0, "R8 group boundary");
    drive(32'h0FFF_FFFF, 32'h0, 1'b1, "R8 seven groups");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 top generate");
    for (int i = 0; i < 300; i++)
      drive($urandom, $urandom, 1'($urandom), "random");
    @(negedge clk);
    wait (sb.size() == 0);
    @(posedge clk); #1;

    // R6: mid-run reset clears live outputs
    @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; carry_in = 1'b1;
    @(posedge clk); #1;
    check("R1 pre-reset nonzero sum", sum_q, 32'hFFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R6 midrun sum", sum_q, '0);
    check("R6 midrun carries", carries_q, '0);
    check("R6 midrun cout", {31'b0, carry_out_q}, '0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule